// File: doc/BRIEF.md
# Ethernet DMA Control Register File

This block holds the software-visible control and status words of a multi-ring Ethernet DMA engine. A host reaches it over a simple word-wide register bus. It holds an event word, an interrupt mask, one halt-status word for the transmit rings and one for the receive rings, a read-write mode word, a write-only command word and a read-only identity word. It also holds eight transmit and eight receive ring base addresses, and each base has a current descriptor pointer beside it.

Three interrupt lines come from the enabled events, sorted into a transmit group, a receive group and an error group. Writing a halt-status word acknowledges halts, and each acknowledged ring gets a one-cycle restart strobe towards its descriptor walker. Receive rings obey one extra rule: a receive ring is restarted only when its halt bit was already clear. Writing a ring base aligns the address and reloads that ring's descriptor pointer in the same cycle. Hardware event and halt inputs can set bits in the same cycle that software clears them.

The register bus has no back-pressure. A request is taken on every clock edge where `req_i` is high. A read answers with `rvalid_o` exactly one cycle later, and the host must accept that answer. The strobes and interrupt lines are plain level or pulse signals with no handshake.

Top module: `dma_ctl_regs`

## Requirements
- R1: Every access is a full 32-bit word. The word index is the byte address `addr_i` shifted right by two, and `addr_i[1:0]` is always zero.
- R2: A read request taken at a clock edge raises `rvalid_o` for the following cycle and presents the data on `rdata_o` in that cycle. A cycle without a read request leaves `rvalid_o` low. No request is ever refused.
- R3: The word index map and access types are:
  - 0: event word, write-one-to-clear.
  - 1: mask, read-write.
  - 2: transmit halt word, write-one-to-clear.
  - 3: receive halt word, write-one-to-clear.
  - 4: mode, read-write.
  - 5: command, write-only.
  - 6: identity, read-only.
  - 8+i: transmit base of ring i, read-write.
  - 16+i: transmit pointer of ring i, read-only.
  - 24+i: receive base of ring i, read-write.
  - 32+i: receive pointer of ring i, read-only.
  - Every other index is unmapped.
- R4: A read of the write-only word or of an unmapped index returns zero. A read of any read-write, write-one-to-clear or read-only word returns its stored value.
- R5: A write to a read-write word stores the data, and the mode word appears on `mode_o`. A write to the write-only word stores the data on `cmd_o`. A write to a read-only word, to a pointer or to an unmapped index changes nothing.
- R6: Writing the event word clears each bit where the data is one. A bit set on `evt_set_i` in the same cycle ends up set, because a set beats a clear.
- R7: Each interrupt line is the OR of (event AND mask AND group mask). The group masks are parameters, with defaults of 0x000000F0 for transmit, 0x0000000F for receive and 0xFFFF0000 for error. The lines show the new register values in the cycle after the change.
- R8: In the transmit halt word, bit 31-i belongs to ring i. Writing a one there pulses `tx_restart_o[i]` for exactly the next cycle and clears the bit.
- R9: In the receive halt word, bit 23-i belongs to ring i. A written one pulses `rx_restart_o[i]` only if that bit was zero before the write. All written ones are cleared either way.
- R10: A one on `tx_halt_set_i[i]` or `rx_halt_set_i[i]` sets the ring's halt bit. This set takes priority over a clear written in the same cycle.
- R11: A write to a ring base stores the data with bits 2:0 forced to zero and copies the same aligned value into that ring's pointer.
- R12: Reset loads every word from a parameter table, and the interrupt lines, strobes and `rvalid_o` are low. The default table gives 0xFF000000 for the transmit halt word, 0x00FF0000 for the receive halt word, 0x5E7C0A01 for the identity word and zero for all the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Bus request, taken every cycle it is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte address, word aligned |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after the read request |
| rdata_o | output | 32 | Read data |
| evt_set_i | input | 32 | Hardware event set bits |
| tx_halt_set_i | input | 8 | Transmit ring i has halted |
| rx_halt_set_i | input | 8 | Receive ring i has halted |
| irq_tx_o | output | 1 | Transmit group interrupt |
| irq_rx_o | output | 1 | Receive group interrupt |
| irq_err_o | output | 1 | Error group interrupt |
| tx_restart_o | output | 8 | One-cycle restart strobe per transmit ring |
| rx_restart_o | output | 8 | One-cycle restart strobe per receive ring |
| mode_o | output | 32 | Mode word |
| cmd_o | output | 32 | Command word |

## Verification
Interrupts are exercised with event bits from each group, first masked and then unmasked. This separates the AND with the mask from the per-group OR, and a write-one-to-clear that lands in the same cycle as a hardware set shows which of the two wins. The halt words are written with several rings at once against a mix of already-set and already-clear bits. That pattern tells the unconditional transmit restart apart from the gated receive restart, and it exposes a reversed bit-to-ring mapping. Ring base writes use unaligned data on different rings, so a missing alignment or a pointer copied into the wrong slot shows up. Writes to the read-only, pointer and unmapped words are each followed by a read-back that shows nothing moved.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int NUM_RINGS = 8;
  localparam int DATA_W    = 32;
  localparam int NREG      = 40;

  localparam int IX_EVT  = 0;
  localparam int IX_MSK  = 1;
  localparam int IX_TXH  = 2;
  localparam int IX_RXH  = 3;
  localparam int IX_MODE = 4;
  localparam int IX_CMD  = 5;
  localparam int IX_ID   = 6;
  localparam int IX_TXB  = 8;
  localparam int IX_TXP  = 16;
  localparam int IX_RXB  = 24;
  localparam int IX_RXP  = 32;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_RW, ACC_WO, ACC_W1C, ACC_RO
  } acc_e;

  typedef logic [NREG-1:0][DATA_W-1:0] rst_table_t;

  function automatic acc_e acc_of(input int idx);
    acc_e a;
    if (idx == IX_EVT || idx == IX_TXH || idx == IX_RXH) a = ACC_W1C;
    else if (idx == IX_MSK || idx == IX_MODE) a = ACC_RW;
    else if (idx == IX_CMD) a = ACC_WO;
    else if (idx == IX_ID) a = ACC_RO;
    else if (idx >= IX_TXB && idx < IX_TXB + NUM_RINGS) a = ACC_RW;
    else if (idx >= IX_RXB && idx < IX_RXB + NUM_RINGS) a = ACC_RW;
    else if (idx >= IX_TXP && idx < IX_TXP + NUM_RINGS) a = ACC_RO;
    else if (idx >= IX_RXP && idx < IX_RXP + NUM_RINGS) a = ACC_RO;
    else a = ACC_NONE;
    return a;
  endfunction

  function automatic logic [DATA_W-1:0] apply_write(input acc_e a,
      input logic [DATA_W-1:0] old_v, input logic [DATA_W-1:0] wd);
    logic [DATA_W-1:0] r;
    case (a)
      ACC_RW, ACC_WO: r = wd;
      ACC_W1C:        r = old_v & ~wd;
      default:        r = old_v;
    endcase
    return r;
  endfunction

  function automatic rst_table_t default_resets();
    rst_table_t t;
    t = '0;
    t[IX_TXH] = 32'hFF00_0000;
    t[IX_RXH] = 32'h00FF_0000;
    t[IX_ID]  = 32'h5E7C_0A01;
    return t;
  endfunction
endpackage

// File: rtl/dma_halt_ctl.sv
module dma_halt_ctl #(
  parameter int          NRING          = 8,
  parameter int          DW             = 32,
  parameter int          TOP_BIT        = 31,
  parameter bit          GATE_ON_HALTED = 1'b0,
  parameter logic [DW-1:0] RST          = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NRING-1:0] hw_halt_i,
  output logic [DW-1:0]    stat_o,
  output logic [NRING-1:0] restart_o
);
  logic [DW-1:0]    set_vec;
  logic [DW-1:0]    stat_nx;
  logic [NRING-1:0] rs_nx;

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NRING; i++) set_vec[TOP_BIT-i] = hw_halt_i[i];
  end

  // a hardware halt beats a software acknowledge in the same cycle
  assign stat_nx = (wr_i ? (stat_o & ~wdata_i) : stat_o) | set_vec;

  generate
    if (GATE_ON_HALTED) begin : g_gated
      always_comb begin
        for (int i = 0; i < NRING; i++)
          rs_nx[i] = wr_i && wdata_i[TOP_BIT-i] && !stat_o[TOP_BIT-i];
      end
    end else begin : g_plain
      always_comb begin
        for (int i = 0; i < NRING; i++)
          rs_nx[i] = wr_i && wdata_i[TOP_BIT-i];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      stat_o    <= RST;
      restart_o <= '0;
    end else begin
      stat_o    <= stat_nx;
      restart_o <= rs_nx;
    end
  end

  generate
    for (genvar r = 0; r < NRING; r++) begin : g_chk
      // R8 (transmit) and R9 (receive): a strobe only follows a written one
      assert_restart_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_o[r] |-> $past(wr_i && wdata_i[TOP_BIT-r]));
      // R8 / R9: a written one clears the bit unless hardware sets it
      assert_written_bit_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && wdata_i[TOP_BIT-r] && !hw_halt_i[r]) |=> !stat_o[TOP_BIT-r]);
      assert_hw_halt_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_halt_i[r] |=> stat_o[TOP_BIT-r]);
      if (GATE_ON_HALTED) begin : g_gchk
        assert_gated_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
          restart_o[r] |-> !$past(stat_o[TOP_BIT-r]));
      end
    end
  endgenerate
endmodule

// File: rtl/dma_ring_bank.sv
module dma_ring_bank #(
  parameter int NRING = 8,
  parameter int DW    = 32,
  parameter int ALIGN = 3,
  parameter logic [NRING-1:0][DW-1:0] BASE_RST = '0,
  parameter logic [NRING-1:0][DW-1:0] PTR_RST  = '0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NRING-1:0]          wr_base_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [NRING-1:0][DW-1:0]  base_o,
  output logic [NRING-1:0][DW-1:0]  ptr_o
);
  localparam logic [DW-1:0] KEEP = {{(DW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

  generate
    for (genvar r = 0; r < NRING; r++) begin : g_ring
      always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
          base_o[r] <= BASE_RST[r] & KEEP;
          ptr_o[r]  <= PTR_RST[r] & KEEP;
        end else if (wr_base_i[r]) begin
          base_o[r] <= wdata_i & KEEP;
          ptr_o[r]  <= wdata_i & KEEP;
        end
      end

      assert_ptr_follows_base_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_base_i[r] |=> (ptr_o[r] == ($past(wdata_i) & KEEP)) && (base_o[r] == ptr_o[r]));
      assert_base_aligned_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        base_o[r][ALIGN-1:0] == '0);
    end
  endgenerate
endmodule

// File: rtl/dma_irq_groups.sv
module dma_irq_groups #(
  parameter int            DW     = 32,
  parameter logic [DW-1:0] TX_M   = 32'h0000_00F0,
  parameter logic [DW-1:0] RX_M   = 32'h0000_000F,
  parameter logic [DW-1:0] ERR_M  = 32'hFFFF_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_nx_i,
  input  logic [DW-1:0] msk_nx_i,
  output logic          irq_tx_o,
  output logic          irq_rx_o,
  output logic          irq_err_o
);
  localparam int NGRP = 3;
  localparam logic [NGRP-1:0][DW-1:0] GMASK = {ERR_M, RX_M, TX_M};

  logic [NGRP-1:0] line_nx;
  logic [NGRP-1:0] line_q;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign line_nx[g] = |(evt_nx_i & msk_nx_i & GMASK[g]);
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= line_nx;
  end

  assign irq_tx_o  = line_q[0];
  assign irq_rx_o  = line_q[1];
  assign irq_err_o = line_q[2];
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_regs_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [31:0]       TX_GRP   = 32'h0000_00F0,
  parameter logic [31:0]       RX_GRP   = 32'h0000_000F,
  parameter logic [31:0]       ERR_GRP  = 32'hFFFF_0000,
  parameter rst_table_t        RST_TAB  = default_resets()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o,
  input  logic [31:0]       evt_set_i,
  input  logic [7:0]        tx_halt_set_i,
  input  logic [7:0]        rx_halt_set_i,
  output logic              irq_tx_o,
  output logic              irq_rx_o,
  output logic              irq_err_o,
  output logic [7:0]        tx_restart_o,
  output logic [7:0]        rx_restart_o,
  output logic [31:0]       mode_o,
  output logic [31:0]       cmd_o
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int RING_W = $clog2(NUM_RINGS);

  logic [IDX_W-1:0] idx;
  int               idx_i;
  acc_e             acc;
  logic             wr, rd;

  assign idx   = addr_i[ADDR_W-1:2];
  assign idx_i = int'(idx);
  assign acc   = acc_of(idx_i);
  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;

  // ---------------- scalar words ----------------
  logic [31:0] evt_q, msk_q, id_q;
  logic [31:0] evt_nx, msk_nx;
  logic        wr_evt, wr_msk;

  assign wr_evt = wr && (idx_i == IX_EVT);
  assign wr_msk = wr && (idx_i == IX_MSK);
  assign evt_nx = (wr_evt ? apply_write(ACC_W1C, evt_q, wdata_i) : evt_q) | evt_set_i;
  assign msk_nx = wr_msk ? apply_write(ACC_RW, msk_q, wdata_i) : msk_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      evt_q  <= RST_TAB[IX_EVT];
      msk_q  <= RST_TAB[IX_MSK];
      mode_o <= RST_TAB[IX_MODE];
      cmd_o  <= RST_TAB[IX_CMD];
      id_q   <= RST_TAB[IX_ID];
    end else begin
      evt_q <= evt_nx;
      msk_q <= msk_nx;
      if (wr && idx_i == IX_MODE) mode_o <= apply_write(acc, mode_o, wdata_i);
      if (wr && idx_i == IX_CMD)  cmd_o  <= apply_write(acc, cmd_o, wdata_i);
      if (wr && idx_i == IX_ID)   id_q   <= apply_write(acc, id_q, wdata_i);
    end
  end

  // ---------------- halt words ----------------
  logic [31:0] txh_q, rxh_q;

  dma_halt_ctl #(
    .NRING(NUM_RINGS), .DW(32), .TOP_BIT(31), .GATE_ON_HALTED(1'b0),
    .RST(RST_TAB[IX_TXH])
  ) u_txh (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr && idx_i == IX_TXH), .wdata_i(wdata_i),
    .hw_halt_i(tx_halt_set_i), .stat_o(txh_q), .restart_o(tx_restart_o)
  );

  dma_halt_ctl #(
    .NRING(NUM_RINGS), .DW(32), .TOP_BIT(23), .GATE_ON_HALTED(1'b1),
    .RST(RST_TAB[IX_RXH])
  ) u_rxh (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr && idx_i == IX_RXH), .wdata_i(wdata_i),
    .hw_halt_i(rx_halt_set_i), .stat_o(rxh_q), .restart_o(rx_restart_o)
  );

  // ---------------- ring banks ----------------
  logic [NUM_RINGS-1:0]        tx_wr, rx_wr;
  logic [NUM_RINGS-1:0][31:0]  tx_base, tx_ptr, rx_base, rx_ptr;

  generate
    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_dec
      assign tx_wr[r] = wr && (idx_i == IX_TXB + r);
      assign rx_wr[r] = wr && (idx_i == IX_RXB + r);
    end
  endgenerate

  dma_ring_bank #(
    .NRING(NUM_RINGS), .DW(32), .ALIGN(3),
    .BASE_RST(RST_TAB[IX_TXB+NUM_RINGS-1:IX_TXB]),
    .PTR_RST(RST_TAB[IX_TXP+NUM_RINGS-1:IX_TXP])
  ) u_txring (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_base_i(tx_wr), .wdata_i(wdata_i),
    .base_o(tx_base), .ptr_o(tx_ptr)
  );

  dma_ring_bank #(
    .NRING(NUM_RINGS), .DW(32), .ALIGN(3),
    .BASE_RST(RST_TAB[IX_RXB+NUM_RINGS-1:IX_RXB]),
    .PTR_RST(RST_TAB[IX_RXP+NUM_RINGS-1:IX_RXP])
  ) u_rxring (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_base_i(rx_wr), .wdata_i(wdata_i),
    .base_o(rx_base), .ptr_o(rx_ptr)
  );

  // ---------------- interrupts ----------------
  dma_irq_groups #(.DW(32), .TX_M(TX_GRP), .RX_M(RX_GRP), .ERR_M(ERR_GRP)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_nx_i(evt_nx), .msk_nx_i(msk_nx),
    .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .irq_err_o(irq_err_o)
  );

  // ---------------- read path ----------------
  logic [31:0]       stored, rd_nx;
  logic [RING_W-1:0] ring;

  assign ring = idx[RING_W-1:0];

  always_comb begin
    stored = '0;
    if      (idx_i == IX_EVT)  stored = evt_q;
    else if (idx_i == IX_MSK)  stored = msk_q;
    else if (idx_i == IX_TXH)  stored = txh_q;
    else if (idx_i == IX_RXH)  stored = rxh_q;
    else if (idx_i == IX_MODE) stored = mode_o;
    else if (idx_i == IX_CMD)  stored = cmd_o;
    else if (idx_i == IX_ID)   stored = id_q;
    else if (idx_i >= IX_TXB && idx_i < IX_TXB + NUM_RINGS) stored = tx_base[ring];
    else if (idx_i >= IX_TXP && idx_i < IX_TXP + NUM_RINGS) stored = tx_ptr[ring];
    else if (idx_i >= IX_RXB && idx_i < IX_RXB + NUM_RINGS) stored = rx_base[ring];
    else if (idx_i >= IX_RXP && idx_i < IX_RXP + NUM_RINGS) stored = rx_ptr[ring];
    case (acc)
      ACC_RW, ACC_W1C, ACC_RO: rd_nx = stored;
      default:                 rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd;
      if (rd) rdata_o <= rd_nx;
    end
  end

  // ---------------- checks ----------------
  assert_word_aligned_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> (addr_i[1:0] == 2'b00));
  assert_read_answers_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);
  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);
  assert_ro_word_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(id_q));
  assert_evt_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_set_i) |=> ((evt_q & $past(evt_set_i)) == $past(evt_set_i)));
  assert_irq_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (irq_tx_o == |(evt_q & msk_q & TX_GRP)));
  assert_irq_rx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (irq_rx_o == |(evt_q & msk_q & RX_GRP)));
  assert_irq_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (irq_err_o == |(evt_q & msk_q & ERR_GRP)));
endmodule

// File: tb/sim_dma_ctl_regs.sv
module sim_dma_ctl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n, req, we, rvalid, irq_tx, irq_rx, irq_err;
  logic [AW-1:0] addr;
  logic [31:0] wdata, rdata, evt_set, mode, cmd;
  logic [7:0]  txs, rxs, tx_rs, rx_rs;

  dma_ctl_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rvalid_o(rvalid), .rdata_o(rdata), .evt_set_i(evt_set),
    .tx_halt_set_i(txs), .rx_halt_set_i(rxs), .irq_tx_o(irq_tx),
    .irq_rx_o(irq_rx), .irq_err_o(irq_err), .tx_restart_o(tx_rs),
    .rx_restart_o(rx_rs), .mode_o(mode), .cmd_o(cmd)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] snap_tx, snap_rx;
  logic [2:0] snap_irq; // {err, rx, tx}

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle with optional hardware set inputs; snapshots outputs after the edge
  task automatic op(bit wr, int idx, logic [31:0] d, logic [31:0] es,
                    logic [7:0] ts, logic [7:0] rs);
    @(negedge clk);
    req = wr; we = wr; addr = AW'(idx * 4); wdata = d;
    evt_set = es; txs = ts; rxs = rs;
    @(posedge clk); #1;
    snap_tx = tx_rs; snap_rx = rx_rs; snap_irq = {irq_err, irq_rx, irq_tx};
    @(negedge clk);
    req = 0; we = 0; evt_set = '0; txs = '0; rxs = '0;
  endtask

  task automatic wr_word(int idx, logic [31:0] d);
    op(1'b1, idx, d, '0, '0, '0);
  endtask

  task automatic rd_check(string tag, int idx, logic [31:0] exp);
    @(negedge clk);
    req = 1; we = 0; addr = AW'(idx * 4);
    @(posedge clk); #1;
    check({tag, " rvalid (R2)"}, {31'd0, rvalid}, 32'd1);
    check(tag, rdata, exp);
    @(negedge clk);
    req = 0;
    @(posedge clk); #1;
    check({tag, " rvalid drop (R2)"}, {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_reset;
    check("R12 irq lines after reset", {29'd0, irq_err, irq_rx, irq_tx}, 32'd0);
    check("R12 tx strobes after reset", {24'd0, tx_rs}, 32'd0);
    check("R12 rx strobes after reset", {24'd0, rx_rs}, 32'd0);
    check("R12 rvalid after reset", {31'd0, rvalid}, 32'd0);
    rd_check("R12 event reset", 0, 32'h0);
    rd_check("R12 tx halt reset", 2, 32'hFF00_0000);
    rd_check("R12 rx halt reset", 3, 32'h00FF_0000);
    rd_check("R12 identity reset", 6, 32'h5E7C_0A01);
  endtask

  task automatic t_access;
    wr_word(4, 32'h1234_5678);
    check("R5 mode_o after write", mode, 32'h1234_5678);
    rd_check("R4 read-write readback", 4, 32'h1234_5678);
    wr_word(5, 32'hCAFE_0042);
    check("R5 cmd_o after write", cmd, 32'hCAFE_0042);
    rd_check("R4 write-only reads zero", 5, 32'h0);
    wr_word(6, 32'hFFFF_FFFF);
    rd_check("R5 read-only write ignored", 6, 32'h5E7C_0A01);
    wr_word(7, 32'hA5A5_A5A5);
    rd_check("R4 unmapped reads zero", 7, 32'h0);
    wr_word(45, 32'h0000_1111);
    rd_check("R3 high unmapped reads zero", 45, 32'h0);
    check("R5 unmapped write leaves mode", mode, 32'h1234_5678);
  endtask

  task automatic t_base;
    wr_word(8 + 3, 32'h1000_0007);
    rd_check("R11 tx base 3 aligned", 11, 32'h1000_0000);
    rd_check("R11 tx ptr 3 copied", 19, 32'h1000_0000);
    rd_check("R11 tx ptr 2 untouched", 18, 32'h0);
    wr_word(24 + 5, 32'hABCD_EF0F);
    rd_check("R11 rx base 5 aligned", 29, 32'hABCD_EF08);
    rd_check("R11 rx ptr 5 copied", 37, 32'hABCD_EF08);
    wr_word(37, 32'h0000_0100);
    rd_check("R5 pointer write ignored", 37, 32'hABCD_EF08);
  endtask

  task automatic t_tx_halt;
    wr_word(2, 32'h8400_0000);
    check("R8 restart rings 0 and 5", {24'd0, snap_tx}, 32'h21);
    check("R8 no rx strobe on tx write", {24'd0, snap_rx}, 32'h0);
    @(posedge clk); #1;
    check("R8 strobe lasts one cycle", {24'd0, tx_rs}, 32'h0);
    rd_check("R8 acked bits cleared", 2, 32'h7B00_0000);
    op(1'b1, 2, 32'h8000_0000, '0, 8'h01, '0);
    check("R8 restart ring 0 with set", {24'd0, snap_tx}, 32'h01);
    rd_check("R10 tx set beats clear", 2, 32'hFB00_0000);
  endtask

  task automatic t_rx_halt;
    wr_word(3, 32'h0080_0000);
    check("R9 no restart on halted ring 0", {24'd0, snap_rx}, 32'h0);
    rd_check("R9 bit cleared anyway", 3, 32'h007F_0000);
    wr_word(3, 32'h00C0_0000);
    check("R9 restart ring 0 only", {24'd0, snap_rx}, 32'h01);
    @(posedge clk); #1;
    check("R9 strobe lasts one cycle", {24'd0, rx_rs}, 32'h0);
    rd_check("R9 rings 0 1 cleared", 3, 32'h003F_0000);
    op(1'b0, 0, '0, '0, '0, 8'h02);
    rd_check("R10 rx ring 1 set", 3, 32'h007F_0000);
  endtask

  task automatic t_evt_irq;
    op(1'b0, 0, '0, 32'h0000_0010, '0, '0);
    check("R7 masked tx event no irq", {29'd0, snap_irq}, 32'h0);
    rd_check("R6 event set by hardware", 0, 32'h0000_0010);
    wr_word(1, 32'h0000_0010);
    check("R7 tx irq after mask", {29'd0, snap_irq}, 32'h1);
    op(1'b0, 0, '0, 32'h0000_0001, '0, '0);
    check("R7 rx event still masked", {29'd0, snap_irq}, 32'h1);
    wr_word(1, 32'h0001_0011);
    check("R7 tx and rx irq", {29'd0, snap_irq}, 32'h3);
    op(1'b0, 0, '0, 32'h0001_0000, '0, '0);
    check("R7 error irq", {29'd0, snap_irq}, 32'h7);
    wr_word(0, 32'h0000_0010);
    check("R6 w1c drops tx irq", {29'd0, snap_irq}, 32'h6);
    rd_check("R6 event after w1c", 0, 32'h0001_0001);
    op(1'b1, 0, 32'h0001_0001, 32'h0000_0001, '0, '0);
    check("R6 set beats clear irq", {29'd0, snap_irq}, 32'h2);
    rd_check("R6 set beats clear value", 0, 32'h0000_0001);
    rd_check("R3 mask readback", 1, 32'h0001_0011);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req = 0; we = 0; addr = '0; wdata = '0;
    evt_set = '0; txs = '0; rxs = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_access();
    t_base();
    t_tx_halt();
    t_rx_halt();
    t_evt_irq();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule